// File: doc/BRIEF.md
# Read Termination Window Generator

This block drives the on-die termination enable of a DDR-style data interface. Each read command opens a window of active termination. The window opens after a delay made of a round-trip alignment value plus an enable offset. The window length is set by the burst length plus a disable offset. Both offsets are the saturating sum of a base field and a trim field, counted in whole clocks. A read that arrives while an earlier window is still pending or open merges with that window.

A static hold mode keeps termination on while reads are in progress and while the bus is idle. Write commands always win over both reads and the hold mode. While the local pins drive write data, and for a programmable number of clocks after the data ends, termination is held off. A second registered output marks the cycle just before a read window turns termination on. The physical layer uses this flag to launch the enable on the falling edge half a clock early.

Top module: `odt_window_gen`

## Requirements
- R1: While rst_n is low at a rising edge, the next cycle shows odt_en = 0 and odt_early = 0. Reset also discards every pending read window and every pending write block.
- R2: With hold_on = 0 and no write in progress, a read command in cycle k first drives odt_en high in cycle k + 2 + rt_align + S_on, where S_on = min(on_base + on_trim, 7).
- R3: When bl8 = 0 (4-beat bursts), an isolated read keeps odt_en high for 2 + S_off consecutive cycles, where S_off = min(off_base + off_trim, 7).
- R4: When bl8 = 1 (8-beat bursts), an isolated read keeps odt_en high for 4 + S_off consecutive cycles.
- R5: Each offset sum saturates at 7. A base of 6 with a trim of 5 therefore acts as 7.
- R6: odt_early is high in cycle c exactly when all of the following hold: no read window covers c, a read window covers c + 1, cycle c + 1 is not write-blocked, and hold_on was 0 in cycle c − 1. When odt_early is high, odt_en is low in that cycle and high in the next.
- R7: The windows of several reads are joined. Where windows overlap or touch, odt_en stays high without a gap until the latest window ends.
- R8: A write command in cycle k forces odt_en low in cycles k + 2 through k + 1 + B + wr_hold. B is 2 when bl8 = 0 and 4 when bl8 = 1. This applies even inside a read window or under hold_on.
- R9: hold_on = 1 in cycle c drives odt_en high in cycle c + 1 unless a write block covers c + 1.
- R10: The offsets, burst length and alignment are sampled in the cycle of the command. Changing them afterwards does not move a window that is already scheduled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_cmd | input | 1 | Read command strobe |
| wr_cmd | input | 1 | Write command strobe |
| bl8 | input | 1 | 1 selects 8-beat bursts, 0 selects 4-beat bursts |
| on_base | input | 3 | Enable offset, base part |
| on_trim | input | 3 | Enable offset, trim part |
| off_base | input | 3 | Disable offset, base part |
| off_trim | input | 3 | Disable offset, trim part |
| rt_align | input | 4 | Round-trip alignment in clocks |
| wr_hold | input | 3 | Extra clocks of blocking after write data |
| hold_on | input | 1 | Static termination hold |
| odt_en | output | 1 | Termination enable |
| odt_early | output | 1 | Marks the cycle before a read window turns termination on |

## Verification
A read in cycle k reaches odt_en at k + 2 + rt_align + S_on. A write in cycle k blocks odt_en from k + 2. A change of hold_on shows on odt_en one cycle later. odt_early is judged against the read coverage of its own cycle and of the next cycle. The driver records each command on the cycle index where it is applied and marks every future cycle it affects in scoreboard arrays. A reset clears all marks from two cycles on. The monitor samples 1 ns after each rising edge and compares both outputs with the marks for that cycle index. Every cycle is therefore checked at the exact cycle its result is due.

// File: rtl/odt_win_pkg.sv
package odt_win_pkg;

    // Registered outputs of the window generator
    typedef struct packed {
        logic en;
        logic early;
    } odt_pins_t;

endpackage

// File: rtl/odt_span_calc.sv
module odt_span_calc #(
    parameter int FW      = 3,
    parameter int RTW     = 4,
    parameter int IW      = 6,
    parameter int BL4_CLK = 2,
    parameter int BL8_CLK = 4
) (
    input  logic [FW-1:0]  on_base,
    input  logic [FW-1:0]  on_trim,
    input  logic [FW-1:0]  off_base,
    input  logic [FW-1:0]  off_trim,
    input  logic [RTW-1:0] rt_align,
    input  logic [FW-1:0]  wr_hold,
    input  logic           bl8,
    output logic [IW-1:0]  rd_start,
    output logic [IW-1:0]  rd_span,
    output logic [IW-1:0]  wr_span
);

    logic [FW:0]   on_raw, off_raw;
    logic [FW-1:0] on_sat, off_sat;
    logic [IW-1:0] burst_clk;

    always_comb begin
        on_raw    = {1'b0, on_base} + {1'b0, on_trim};
        off_raw   = {1'b0, off_base} + {1'b0, off_trim};
        on_sat    = on_raw[FW]  ? '1 : on_raw[FW-1:0];
        off_sat   = off_raw[FW] ? '1 : off_raw[FW-1:0];
        burst_clk = bl8 ? IW'(BL8_CLK) : IW'(BL4_CLK);
        rd_start  = IW'(rt_align) + IW'(on_sat);
        rd_span   = burst_clk + IW'(off_sat);
        wr_span   = burst_clk + IW'(wr_hold);
    end

endmodule

// File: rtl/odt_slot_sched.sv
module odt_slot_sched #(
    parameter int DEPTH = 33,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [IW-1:0] start,
    input  logic [IW-1:0] span,
    output logic          slot_now,
    output logic          slot_next
);

    typedef struct packed {
        logic [DEPTH-1:0] sch;
    } sched_t;

    sched_t st_d, st_q;

    always_comb begin
        st_d.sch = st_q.sch >> 1;
        if (fire) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i >= int'(start) && i < int'(start) + int'(span)) begin
                    st_d.sch[i] = 1'b1;
                end
            end
        end
        if (!rst_n) begin
            st_d.sch = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign slot_now  = st_q.sch[0];
    assign slot_next = st_d.sch[0];

    // R7
    slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && span != '0) |=> (st_q.sch != '0));

endmodule

// File: rtl/odt_window_gen.sv
module odt_window_gen #(
    parameter int FW      = 3,
    parameter int RTW     = 4,
    parameter int BL4_CLK = 2,
    parameter int BL8_CLK = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_cmd,
    input  logic           wr_cmd,
    input  logic           bl8,
    input  logic [FW-1:0]  on_base,
    input  logic [FW-1:0]  on_trim,
    input  logic [FW-1:0]  off_base,
    input  logic [FW-1:0]  off_trim,
    input  logic [RTW-1:0] rt_align,
    input  logic [FW-1:0]  wr_hold,
    input  logic           hold_on,
    output logic           odt_en,
    output logic           odt_early
);
    import odt_win_pkg::*;

    localparam int SUM_MAX = (1 << FW) - 1;
    localparam int RT_MAX  = (1 << RTW) - 1;
    localparam int DEPTH   = RT_MAX + 2 * SUM_MAX + BL8_CLK;
    localparam int IW      = $clog2(DEPTH + 1);

    logic [IW-1:0] rd_start, rd_span, wr_span;
    logic          rd_now, rd_next, wr_now, wr_next;
    odt_pins_t     out_d, out_q;

    odt_span_calc #(
        .FW(FW), .RTW(RTW), .IW(IW), .BL4_CLK(BL4_CLK), .BL8_CLK(BL8_CLK)
    ) u_calc (
        .on_base (on_base),
        .on_trim (on_trim),
        .off_base(off_base),
        .off_trim(off_trim),
        .rt_align(rt_align),
        .wr_hold (wr_hold),
        .bl8     (bl8),
        .rd_start(rd_start),
        .rd_span (rd_span),
        .wr_span (wr_span)
    );

    odt_slot_sched #(.DEPTH(DEPTH), .IW(IW)) u_rd_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (rd_cmd),
        .start    (rd_start),
        .span     (rd_span),
        .slot_now (rd_now),
        .slot_next(rd_next)
    );

    odt_slot_sched #(.DEPTH(DEPTH), .IW(IW)) u_wr_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (wr_cmd),
        .start    ('0),
        .span     (wr_span),
        .slot_now (wr_now),
        .slot_next(wr_next)
    );

    always_comb begin
        out_d = '0;
        if (rst_n) begin
            out_d.en    = (hold_on | rd_now) & ~wr_now;
            out_d.early = rd_next & ~rd_now & ~wr_next & ~hold_on;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign odt_en    = out_q.en;
    assign odt_early = out_q.early;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!odt_en && !odt_early));

    // R6
    early_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        odt_early |=> odt_en);

    // R6
    early_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        odt_early |-> !odt_en);

    // R8
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> ##1 !odt_en);

    // R9
    hold_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_on && !wr_now) |=> odt_en);

endmodule

// File: tb/odt_window_gen_bench.sv
`timescale 1ns/1ps
module odt_window_gen_bench;

    localparam int NC = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_cmd = 1'b0, wr_cmd = 1'b0, bl8 = 1'b0, hold_on = 1'b0;
    logic [2:0] on_base = '0, on_trim = '0, off_base = 3'd2, off_trim = 3'd1, wr_hold = '0;
    logic [3:0] rt_align = 4'd3;
    logic       odt_en, odt_early;

    bit    win [NC];
    bit    blk [NC];
    bit    ovr [NC];
    bit    rsts[NC];
    int    cyc = 0;
    int    n_run = 0, n_fail = 0;
    bit    done = 1'b0;
    bit    checking = 1'b0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    odt_window_gen u_odt_window_gen (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .bl8(bl8),
        .on_base(on_base), .on_trim(on_trim), .off_base(off_base), .off_trim(off_trim),
        .rt_align(rt_align), .wr_hold(wr_hold), .hold_on(hold_on),
        .odt_en(odt_en), .odt_early(odt_early)
    );

    function automatic int sat7(input int a, input int b);
        return (a + b > 7) ? 7 : a + b;
    endfunction

    // Scoreboard bookkeeping for the cycle the inputs were just applied in
    task automatic record(input bit r, input bit w);
        ovr[cyc]  = hold_on;
        rsts[cyc] = !rst_n;
        if (!rst_n) begin
            for (int c = cyc + 2; c < cyc + 70 && c < NC; c++) begin
                win[c] = 1'b0;
                blk[c] = 1'b0;
            end
        end else begin
            if (r) begin
                int d = int'(rt_align) + sat7(int'(on_base), int'(on_trim));
                int l = (bl8 ? 4 : 2) + sat7(int'(off_base), int'(off_trim));
                for (int j = 0; j < l; j++) win[cyc + 2 + d + j] = 1'b1;
            end
            if (w) begin
                int l = (bl8 ? 4 : 2) + int'(wr_hold);
                for (int j = 0; j < l; j++) blk[cyc + 2 + j] = 1'b1;
            end
        end
    endtask

    task automatic step(input bit r, input bit w);
        @(negedge clk);
        rd_cmd = r;
        wr_cmd = w;
        record(r, w);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic set_fields(input int ob, input int ot, input int fb, input int ft,
                              input int rt, input int wh, input bit b8);
        @(negedge clk);
        rd_cmd = 1'b0; wr_cmd = 1'b0;
        on_base = 3'(ob); on_trim = 3'(ot); off_base = 3'(fb); off_trim = 3'(ft);
        rt_align = 4'(rt); wr_hold = 3'(wh); bl8 = b8;
        record(1'b0, 1'b0);
    endtask

    task automatic set_ctl(input bit rn, input bit ho);
        @(negedge clk);
        rd_cmd = 1'b0; wr_cmd = 1'b0;
        rst_n = rn; hold_on = ho;
        record(1'b0, 1'b0);
    endtask

    // Monitor: compares each cycle with the scoreboard marks
    initial begin
        rsts[0] = 1'b1;
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            if (checking && cyc >= 2 && cyc < NC - 1) begin
                bit e_en, e_early;
                e_en    = rsts[cyc-1] ? 1'b0 : ((ovr[cyc-1] | win[cyc]) & ~blk[cyc]);
                e_early = rsts[cyc-1] ? 1'b0
                        : (win[cyc+1] & ~win[cyc] & ~blk[cyc+1] & ~ovr[cyc-1]);
                n_run++;
                if (odt_en !== e_en) begin
                    n_fail++;
                    $display("FAIL %s odt_en cycle %0d: actual %b expected %b",
                             phase, cyc, odt_en, e_en);
                end
                n_run++;
                if (odt_early !== e_early) begin
                    n_fail++;
                    $display("FAIL R6 (%s) odt_early cycle %0d: actual %b expected %b",
                             phase, cyc, odt_early, e_early);
                end
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        checking = 1'b1;
        // R1: reset state
        phase = "R1";
        set_ctl(1'b0, 1'b0);
        idle(3);
        set_ctl(1'b1, 1'b0);
        idle(4);

        // R2 R3: 4-beat burst, start delay 3, length 5
        phase = "R2_R3";
        set_fields(0, 0, 2, 1, 3, 0, 1'b0);
        step(1'b1, 1'b0);
        idle(20);

        // R4: 8-beat burst, length 7
        phase = "R4";
        set_fields(0, 0, 2, 1, 3, 0, 1'b1);
        step(1'b1, 1'b0);
        idle(20);

        // R2: zero alignment, enable offset 1+2
        phase = "R2";
        set_fields(1, 2, 0, 0, 0, 0, 1'b0);
        step(1'b1, 1'b0);
        idle(16);
        set_fields(0, 0, 0, 0, 0, 0, 1'b0);
        step(1'b1, 1'b0);
        idle(10);

        // R5: saturating sums
        phase = "R5";
        set_fields(6, 5, 7, 7, 2, 0, 1'b0);
        step(1'b1, 1'b0);
        idle(30);

        // R7: overlapping and touching reads merge
        phase = "R7";
        set_fields(0, 0, 2, 1, 3, 0, 1'b0);
        step(1'b1, 1'b0);
        idle(2);
        step(1'b1, 1'b0);
        idle(4);
        step(1'b1, 1'b0);
        idle(20);

        // R10: fields changed after the read do not move it
        phase = "R10";
        set_fields(0, 0, 0, 0, 1, 0, 1'b0);
        step(1'b1, 1'b0);
        set_fields(7, 7, 7, 7, 15, 7, 1'b1);
        idle(30);

        // R8: write inside a read window
        phase = "R8";
        set_fields(0, 0, 2, 1, 3, 2, 1'b0);
        step(1'b1, 1'b0);
        idle(3);
        step(1'b0, 1'b1);
        idle(20);
        set_fields(0, 0, 2, 1, 3, 1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        idle(20);

        // R9: hold mode with a write inside it
        phase = "R9";
        set_ctl(1'b1, 1'b1);
        idle(5);
        step(1'b1, 1'b0);
        idle(3);
        step(1'b0, 1'b1);
        idle(12);
        set_ctl(1'b1, 1'b0);
        idle(15);

        // R1: reset in the middle of a window discards it
        phase = "R1";
        set_fields(0, 0, 7, 0, 2, 3, 1'b1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        idle(5);
        set_ctl(1'b0, 1'b0);
        idle(2);
        set_ctl(1'b1, 1'b0);
        idle(20);

        done = 1'b1;
        checking = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule